// File: doc/BRIEF.md
# Row/Column Hit Timestamp and Pulse-Width Tagger

This block sits between the OR'd row and column discriminator lines of a pixel matrix and a serial readout engine. Each line is its own channel. When a channel's pulse begins, the block keeps a copy of a slow, free-running global time count. While the pulse stays high, a fast per-channel counter measures its width as time over threshold (ToT). When the pulse ends, the channel raises a request, and a fixed-priority arbiter moves one finished channel per cycle into a small first-in first-out record store.

The block raises an active-high enable for an external open-drain pull-down whenever the store holds a record. The readout engine only starts working when the shared line goes low. It then drains the records with a show-ahead pop interface. Everything runs on the fast clock. The slow time reference arrives as a plain input that is synchronised and edge-detected inside the block. Each hit line also passes through a two-stage synchroniser.

Each channel is a three-state machine. `CH_IDLE` moves to `CH_ACTIVE` on a detected rising edge, which loads the time count and sets ToT to 1. `CH_ACTIVE` stays put while the synchronised line is high, adding 1 to ToT each cycle. It moves to `CH_PENDING` on the first low cycle. `CH_PENDING` returns to `CH_IDLE` in the cycle its grant is given. Edges seen in `CH_PENDING` do not start a new measurement.

Top module: `hit_tagger`

## Requirements
- R1: After reset, `rec_valid`, `drdy_pull` and `overflow` are 0, and the record store is empty.
- R2: A hit line held high for W fast-clock cycles gives a record whose ToT field equals W.
- R3: ToT saturates at 4095. A pulse longer than 4095 cycles reports 4095 and does not wrap.
- R4: The timestamp field equals the number of rising edges on `ts_clk` since reset, modulo 256, as counted when the hit rises. This holds when `ts_clk` does not change within 4 cycles of the hit edge.
- R5: The timestamp counter wraps from 255 to 0.
- R6: A record is 27 bits wide. Bit 26 is 0 for a row and 1 for a column. Bits 25:20 hold the row or column index, bits 19:12 the timestamp and bits 11:0 the ToT.
- R7: Channels whose pulses end in the same cycle are all recorded. Rows come before columns, and within each group the lower index comes first.
- R8: `drdy_pull` is 1 exactly while `rec_valid` is 1, which is while the store is not empty.
- R9: The store holds 16 records. A record offered while it already holds 16 is dropped, and `overflow` becomes 1 and stays 1 until reset. The 16 stored records are kept in order.
- R10: `rec_data` shows the oldest record while `rec_valid` is 1. A cycle with `rec_pop` high removes that record, and records leave in the order they were written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock for all logic |
| rst | input | 1 | Synchronous reset, active high |
| ts_clk | input | 1 | Slow time reference, asynchronous to clk |
| row_hit | input | N_ROWS | OR'd row discriminator lines |
| col_hit | input | N_COLS | OR'd column discriminator lines |
| rec_pop | input | 1 | Removes the head record |
| rec_valid | output | 1 | Head record is present |
| rec_data | output | 27 | Head record {is_col, index, timestamp, ToT} |
| drdy_pull | output | 1 | Enable for the open-drain pull-down of the shared ready line |
| overflow | output | 1 | Sticky flag: a record was dropped |

## Verification
The hardest case to reach from the ports is several channels leaving `CH_ACTIVE` in the same cycle, each with a different ToT. To get there, the bench raises the lines one cycle apart in descending channel order and drops them all together. The arbiter must then pull the records out in the reverse of their start order, and each ToT tells which channel the record came from. The bench also fills the store to its 16-record limit without popping, offers further records, and checks that exactly the first 16 come out.

// File: rtl/hit_tagger_pkg.sv
package hit_tagger_pkg;

    localparam int TS_W  = 8;
    localparam int TOT_W = 12;
    localparam int IDX_W = 6;

    typedef enum logic [1:0] {
        CH_IDLE    = 2'd0,
        CH_ACTIVE  = 2'd1,
        CH_PENDING = 2'd2
    } ch_state_e;

    typedef struct packed {
        logic               is_col;
        logic [IDX_W-1:0]   idx;
        logic [TS_W-1:0]    ts;
        logic [TOT_W-1:0]   tot;
    } hit_rec_t;

    localparam int REC_W = $bits(hit_rec_t);

endpackage

// File: rtl/sync2.sv
module sync2 #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= '0;
            q      <= '0;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/ts_counter.sv
module ts_counter #(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ts_clk,
    output logic [TW-1:0] ts_val
);
    logic ref_s;
    logic ref_prev;
    logic ref_rise;

    sync2 #(.W(1)) u_sync (.clk(clk), .rst(rst), .d(ts_clk), .q(ref_s));

    assign ref_rise = ref_s & ~ref_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            ref_prev <= 1'b0;
            ts_val   <= '0;
        end else begin
            ref_prev <= ref_s;
            if (ref_rise)
                ts_val <= ts_val + 1'b1;
        end
    end

    // R4/R5: the count only ever moves forward by one, wrapping naturally
    a_r5_ts_single_step: assert property (@(posedge clk) disable iff (rst)
        !$stable(ts_val) |-> ts_val == $past(ts_val) + 1'b1);
endmodule

// File: rtl/hit_channel.sv
module hit_channel
    import hit_tagger_pkg::*;
#(
    parameter int TW  = TS_W,
    parameter int CW  = TOT_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          hit_raw,
    input  logic [TW-1:0] ts_now,
    input  logic          grant,
    output logic          req,
    output logic [TW-1:0] ts_out,
    output logic [CW-1:0] tot_out
);
    localparam logic [CW-1:0] TOT_MAX = '1;

    ch_state_e state_q, state_d;
    logic      hit_s;
    logic      hit_prev;
    logic      rise;

    sync2 #(.W(1)) u_sync (.clk(clk), .rst(rst), .d(hit_raw), .q(hit_s));

    assign rise = hit_s & ~hit_prev;

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= CH_IDLE;
            hit_prev <= 1'b0;
        end else begin
            state_q  <= state_d;
            hit_prev <= hit_s;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CH_IDLE:    if (rise)   state_d = CH_ACTIVE;
            CH_ACTIVE:  if (!hit_s) state_d = CH_PENDING;
            CH_PENDING: if (grant)  state_d = CH_IDLE;
            default:                state_d = CH_IDLE;
        endcase
    end

    // measurement registers
    always_ff @(posedge clk) begin
        if (rst) begin
            ts_out  <= '0;
            tot_out <= '0;
        end else if (state_q == CH_IDLE && rise) begin
            ts_out  <= ts_now;
            tot_out <= CW'(1);
        end else if (state_q == CH_ACTIVE && hit_s && tot_out != TOT_MAX) begin
            tot_out <= tot_out + 1'b1;
        end
    end

    // outputs
    always_comb begin
        req = (state_q == CH_PENDING);
    end

    a_r2_tot_counts_up: assert property (@(posedge clk) disable iff (rst)
        (state_q == CH_ACTIVE && hit_s && tot_out != TOT_MAX)
        |=> tot_out == $past(tot_out) + 1'b1);

    a_r3_tot_saturates: assert property (@(posedge clk) disable iff (rst)
        (state_q == CH_ACTIVE && tot_out == TOT_MAX) |=> tot_out == TOT_MAX);
endmodule

// File: rtl/prio_arb.sv
module prio_arb #(
    parameter int N = 8
) (
    input  logic [N-1:0] req,
    output logic [N-1:0] grant,
    output logic         any
);
    always_comb begin
        grant = '0;
        for (int i = 0; i < N; i++) begin
            if (req[i] && grant == '0)
                grant[i] = 1'b1;
        end
    end

    assign any = |req;

    // R7: at most one channel wins, and a request is always served
    always_comb begin
        a_r7_single_winner: assert ($onehot0(grant));
        a_r7_no_starve_cycle: assert (!any || grant != '0);
    end
endmodule

// File: rtl/rec_fifo.sv
module rec_fifo #(
    parameter int W     = 27,
    parameter int DEPTH = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic         valid,
    output logic [W-1:0] dout,
    output logic         ovf
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNTW = $clog2(DEPTH + 1);
    localparam logic [CNTW-1:0] FULL_CNT = CNTW'(DEPTH);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    logic [W-1:0]    mem [DEPTH];
    logic [AW-1:0]   wr_ptr, rd_ptr;
    logic [CNTW-1:0] count;
    logic            push_ok, pop_ok, full;

    assign full    = (count == FULL_CNT);
    assign push_ok = push && !full;
    assign pop_ok  = pop && (count != '0);

    always_ff @(posedge clk) begin
        if (push_ok)
            mem[wr_ptr] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
            ovf    <= 1'b0;
        end else begin
            if (push_ok)
                wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            if (pop_ok)
                rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
            if (push_ok && !pop_ok)
                count <= count + 1'b1;
            else if (pop_ok && !push_ok)
                count <= count - 1'b1;
            if (push && full)
                ovf <= 1'b1;
        end
    end

    assign valid = (count != '0);
    assign dout  = mem[rd_ptr];

    a_r9_ovf_sticky: assert property (@(posedge clk) disable iff (rst)
        ovf |=> ovf);

    a_r9_full_push_flags: assert property (@(posedge clk) disable iff (rst)
        (push && full) |=> ovf);

    a_r10_pop_shrinks: assert property (@(posedge clk) disable iff (rst)
        (pop_ok && !push_ok) |=> count == $past(count) - 1'b1);

    a_r9_never_beyond_depth: assert property (@(posedge clk) disable iff (rst)
        full |=> count <= FULL_CNT);
endmodule

// File: rtl/hit_tagger.sv
module hit_tagger
    import hit_tagger_pkg::*;
#(
    parameter int N_ROWS     = 35,
    parameter int N_COLS     = 35,
    parameter int FIFO_DEPTH = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ts_clk,
    input  logic [N_ROWS-1:0] row_hit,
    input  logic [N_COLS-1:0] col_hit,
    input  logic              rec_pop,
    output logic              rec_valid,
    output logic [REC_W-1:0]  rec_data,
    output logic              drdy_pull,
    output logic              overflow
);
    localparam int N_CH = N_ROWS + N_COLS;

    logic [TS_W-1:0]  ts_now;
    logic [N_CH-1:0]  hit_all;
    logic [N_CH-1:0]  req;
    logic [N_CH-1:0]  grant;
    logic             any_req;
    hit_rec_t         ch_rec [N_CH];
    hit_rec_t         win_rec;

    assign hit_all = {col_hit, row_hit};

    ts_counter #(.TW(TS_W)) u_ts (
        .clk(clk), .rst(rst), .ts_clk(ts_clk), .ts_val(ts_now)
    );

    for (genvar i = 0; i < N_CH; i++) begin : g_ch
        localparam bit IS_COL = (i >= N_ROWS);
        localparam int CH_IDX = IS_COL ? i - N_ROWS : i;

        logic [TS_W-1:0]  ts_i;
        logic [TOT_W-1:0] tot_i;

        hit_channel #(.TW(TS_W), .CW(TOT_W)) u_ch (
            .clk(clk), .rst(rst), .hit_raw(hit_all[i]), .ts_now(ts_now),
            .grant(grant[i]), .req(req[i]), .ts_out(ts_i), .tot_out(tot_i)
        );

        assign ch_rec[i] = '{is_col: IS_COL, idx: IDX_W'(CH_IDX),
                             ts: ts_i, tot: tot_i};
    end

    prio_arb #(.N(N_CH)) u_arb (.req(req), .grant(grant), .any(any_req));

    always_comb begin
        win_rec = '0;
        for (int i = 0; i < N_CH; i++) begin
            if (grant[i])
                win_rec = win_rec | ch_rec[i];
        end
    end

    rec_fifo #(.W(REC_W), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk(clk), .rst(rst), .push(any_req), .din(win_rec),
        .pop(rec_pop), .valid(rec_valid), .dout(rec_data), .ovf(overflow)
    );

    assign drdy_pull = rec_valid;

    a_r8_pull_released_after_reset: assert property (@(posedge clk)
        $past(rst) |-> !drdy_pull);
endmodule

// File: tb/hit_tagger_test.sv
module hit_tagger_test;
    localparam int NR = 4;
    localparam int NC = 4;
    localparam int NCH = NR + NC;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          ts_clk = 1'b0;
    logic [NCH-1:0] hv = '0;
    logic          rec_pop = 1'b0;
    logic          rec_valid;
    logic [26:0]   rec_data;
    logic          drdy_pull;
    logic          overflow;

    int checks = 0;
    int errors = 0;
    int ticks  = 0;
    bit done   = 0;

    always #5 clk = ~clk;

    hit_tagger #(.N_ROWS(NR), .N_COLS(NC), .FIFO_DEPTH(16)) uut (
        .clk(clk), .rst(rst), .ts_clk(ts_clk),
        .row_hit(hv[NR-1:0]), .col_hit(hv[NCH-1:NR]),
        .rec_pop(rec_pop), .rec_valid(rec_valid), .rec_data(rec_data),
        .drdy_pull(drdy_pull), .overflow(overflow)
    );

    // R6 layout: {is_col, idx[5:0], ts[7:0], tot[11:0]}
    function automatic logic [26:0] mk(int ch, int ts, int tot);
        logic col;
        int   idx;
        col = (ch >= NR);
        idx = col ? ch - NR : ch;
        return {col, 6'(idx), 8'(ts % 256), 12'(tot)};
    endfunction

    task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        ts_clk = 1'b1;
        repeat (4) @(negedge clk);
        ts_clk = 1'b0;
        repeat (4) @(negedge clk);
        ticks++;
    endtask

    task automatic pulse(int ch, int w);
        hv[ch] = 1'b1;
        repeat (w) @(negedge clk);
        hv[ch] = 1'b0;
    endtask

    task automatic pop_expect(string tag, logic [26:0] exp);
        check({tag, " valid"}, 64'(rec_valid), 64'd1);
        check(tag, 64'(rec_data), 64'(exp));
        rec_pop = 1'b1;
        @(negedge clk);
        rec_pop = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R1 watchdog actual=timeout expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check("R1 rec_valid", 64'(rec_valid), 64'd0);
        check("R1 drdy_pull", 64'(drdy_pull), 64'd0);
        check("R1 overflow", 64'(overflow), 64'd0);

        // R2 R4 R6 R8 R10: sweep every channel over widths 1..12
        for (int w = 1; w <= 12; w++) begin
            for (int ch = 0; ch < NCH; ch++) begin
                tick();
                pulse(ch, w);
                repeat (8) @(negedge clk);
                check("R8 pull while data", 64'(drdy_pull), 64'd1);
                pop_expect("R2 R4 R6 R10 sweep", mk(ch, ticks, w));
                check("R8 release when empty", 64'(drdy_pull), 64'd0);
            end
        end

        // R3 saturation
        pulse(2, 4094);
        repeat (8) @(negedge clk);
        pop_expect("R3 below limit", mk(2, ticks, 4094));
        pulse(6, 5000);
        repeat (8) @(negedge clk);
        pop_expect("R3 saturate", mk(6, ticks, 4095));

        // R7 all channels end together, staggered starts: ch k width 6+k
        for (int s = 0; s < NCH; s++) begin
            hv[NCH-1-s] = 1'b1;
            @(negedge clk);
        end
        repeat (5) @(negedge clk);
        hv = '0;
        repeat (20) @(negedge clk);
        for (int k = 0; k < NCH; k++)
            pop_expect("R7 priority order", mk(k, ticks, 6 + k));
        check("R7 nothing extra", 64'(rec_valid), 64'd0);

        // R7 subset {6,1,4} ending together
        hv[6] = 1'b1; hv[1] = 1'b1; hv[4] = 1'b1;
        repeat (4) @(negedge clk);
        hv = '0;
        repeat (12) @(negedge clk);
        pop_expect("R7 subset first", mk(1, ticks, 4));
        pop_expect("R7 subset second", mk(4, ticks, 4));
        pop_expect("R7 subset third", mk(6, ticks, 4));

        // R5 wrap of the timestamp
        while (ticks < 256 || (ticks % 256) != 1) tick();
        pulse(5, 2);
        repeat (8) @(negedge clk);
        pop_expect("R5 wrapped ts", mk(5, 1, 2));

        // R9 overflow: 20 records with no pop
        for (int i = 0; i < 20; i++) begin
            pulse(i % NCH, 3);
            repeat (10) @(negedge clk);
            if (i == 15)
                check("R9 no overflow at 16", 64'(overflow), 64'd0);
        end
        check("R9 overflow set", 64'(overflow), 64'd1);
        for (int i = 0; i < 16; i++)
            pop_expect("R9 R10 retained order", mk(i % NCH, ticks, 3));
        check("R9 dropped records absent", 64'(rec_valid), 64'd0);
        check("R8 released after drain", 64'(drdy_pull), 64'd0);
        check("R9 overflow sticky", 64'(overflow), 64'd1);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule